// File: doc/BRIEF.md
# Peak-Hold Current Limit Sequencer

This block picks the current-limit setpoint for one current-regulated solenoid driver channel. It follows the channel's PWM drive pulse. When a pulse starts, it presents the high (peak) setpoint code for a programmed number of slow timer ticks. It then presents the low (hold) setpoint code until the pulse ends. Between pulses it presents a code of zero.

Timing is counted in strobes of a 2 MHz tick enable, not in system clocks. The peak duration is an 8-bit value scaled by 64 ticks, so 255 gives 16320 ticks (8.16 ms). Setpoint codes use 475 counts per amp. The high code covers 0 to 1900 (0 to 4 A) and the low code covers 0 to 950 (0 to 2 A). Larger codes are clamped to those ceilings. One instance is placed per current-limited channel, so each channel has its own pair of setpoints and its own peak time.

Top module: `peak_hold_seq`

## Requirements
- R1: After reset the block is idle: `limit_o` is 0 and `peak_o` is 0.
- R2: When `drive_i` is high while the block is idle and `peak_i` is nonzero, then from the next clock on, `peak_o` is 1 and `limit_o` carries the clamped high code.
- R3: The peak phase ends after exactly `peak_i`×64 tick strobes. It counts the strobes present on `tick_i` at clock edges during the phase. While `drive_i` stays high, the phase never ends on a clock without a strobe.
- R4: With `peak_i` equal to 0 at the leading edge, the low setpoint is selected from the first clock of the pulse and `peak_o` stays 0.
- R5: After the peak phase, `limit_o` carries the clamped low code until `drive_i` falls.
- R6: One clock after `drive_i` is low, `limit_o` is 0 and `peak_o` is 0.
- R7: A high code above 1900 is presented as 1900. Codes of 1900 and below pass unchanged.
- R8: A low code above 950 is presented as 950. Codes of 950 and below pass unchanged.
- R9: Every new leading edge of `drive_i` restarts the peak timer from its full length, even when the previous pulse ended during its peak phase.
- R10: `peak_o` is 1 exactly while the high setpoint is selected.
- R11: `peak_i` is captured at the leading edge. A change to it during a pulse does not alter that pulse's peak length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drive_i | input | 1 | PWM drive pulse, high while the switch is commanded closed |
| tick_i | input | 1 | One-clock strobe at 2 MHz |
| hi_code_i | input | 11 | Peak setpoint code |
| lo_code_i | input | 11 | Hold setpoint code |
| peak_i | input | 8 | Peak time in units of 64 ticks |
| limit_o | output | 11 | Active setpoint code, 0 when idle |
| peak_o | output | 1 | High while the peak setpoint is selected |

## Verification
Some rules are checked by the assertions on every clock: the bounds on the presented code, the return to zero once the pulse drops, and that the peak phase only ends on a tick strobe. Entering the peak or hold phase at a leading edge is checked the same way. Only the bench's scenarios can show that the peak length equals the programmed count of strobes, at several strobe rates. The same holds for the clamp values across a grid of codes, for the restart after a pulse cut short, and for the capture of the peak time at the leading edge.

// File: rtl/peak_hold_seq.sv
module peak_hold_seq #(
  parameter int CODE_W     = 11,
  parameter int PEAK_W     = 8,
  parameter int SCALE_LOG2 = 6,
  parameter int HI_MAX     = 1900,
  parameter int LO_MAX     = 950
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drive_i,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] hi_code_i,
  input  logic [CODE_W-1:0] lo_code_i,
  input  logic [PEAK_W-1:0] peak_i,
  output logic [CODE_W-1:0] limit_o,
  output logic              peak_o
);
  localparam int CNT_W = PEAK_W + SCALE_LOG2;

  typedef enum logic [1:0] {S_IDLE, S_PEAK, S_HOLD} phase_t;

  phase_t           st;
  logic [CNT_W-1:0] remain;
  logic [CODE_W-1:0] hi_sat, lo_sat;

  assign hi_sat = (hi_code_i > CODE_W'(HI_MAX)) ? CODE_W'(HI_MAX) : hi_code_i;
  assign lo_sat = (lo_code_i > CODE_W'(LO_MAX)) ? CODE_W'(LO_MAX) : lo_code_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      remain <= '0;
    end else if (!drive_i) begin
      st     <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: begin
          remain <= {peak_i, {SCALE_LOG2{1'b0}}};
          st     <= (peak_i == '0) ? S_HOLD : S_PEAK;
        end
        S_PEAK: if (tick_i) begin
          if (remain == CNT_W'(1)) st <= S_HOLD;
          remain <= remain - CNT_W'(1);
        end
        default: st <= S_HOLD;
      endcase
    end
  end

  assign peak_o  = (st == S_PEAK);
  assign limit_o = (st == S_PEAK) ? hi_sat :
                   (st == S_HOLD) ? lo_sat : '0;

  a_r6_zero_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_i |=> (limit_o == '0 && !peak_o));
  a_r2_peak_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && drive_i && peak_i != '0) |=> peak_o);
  a_r4_direct_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && drive_i && peak_i == '0) |=> (!peak_o && st == S_HOLD));
  a_r3_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (peak_o && drive_i && !tick_i) |=> peak_o);
  a_r7_hi_bound: assert property (@(posedge clk) disable iff (!rst_n)
    peak_o |-> (limit_o <= CODE_W'(HI_MAX)));
  a_r8_lo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !peak_o |-> (limit_o <= CODE_W'(LO_MAX)));
endmodule

// File: tb/peak_hold_seq_tb_top.sv
module peak_hold_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        drive_i = 1'b0;
  logic        tick_i = 1'b0;
  logic [10:0] hi_code_i = '0;
  logic [10:0] lo_code_i = '0;
  logic [7:0]  peak_i = '0;
  logic [10:0] limit_o;
  logic        peak_o;

  int n_chk = 0, n_fail = 0;
  int div = 1, phase = 0, seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  peak_hold_seq dut_i (
    .clk(clk), .rst_n(rst_n), .drive_i(drive_i), .tick_i(tick_i),
    .hi_code_i(hi_code_i), .lo_code_i(lo_code_i), .peak_i(peak_i),
    .limit_o(limit_o), .peak_o(peak_o)
  );

  function automatic int clamp(int v, int mx);
    return (v > mx) ? mx : v;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // at a negedge: present the next tick and count it if the edge will see PEAK
  task automatic step();
    tick_i = (phase == 0);
    phase  = (phase + 1) % div;
    if (tick_i && peak_o) seen++;
    @(negedge clk);
  endtask

  // full pulse: rise, measure peak, hold, drop
  task automatic pulse(int pk, int hi, int lo, int hold_cyc);
    int ehi, elo, guard;
    ehi = clamp(hi, 1900);
    elo = clamp(lo, 950);
    hi_code_i = 11'(hi); lo_code_i = 11'(lo); peak_i = 8'(pk);
    drive_i = 1'b1;
    step();
    if (pk != 0) begin
      check(peak_o == 1'b1, "R2 peak flag", int'(peak_o), 1);
      check(int'(limit_o) == ehi, "R2/R7 high code", int'(limit_o), ehi);
    end else begin
      check(peak_o == 1'b0, "R4 no peak", int'(peak_o), 0);
      check(int'(limit_o) == elo, "R4/R8 low code", int'(limit_o), elo);
    end
    seen = 0; guard = 0;
    while (peak_o && guard < 20000 * div) begin
      if (int'(limit_o) != ehi) check(1'b0, "R10 flag vs code", int'(limit_o), ehi);
      step();
      guard++;
    end
    check(seen == pk * 64, "R3 peak ticks", seen, pk * 64);
    for (int i = 0; i < hold_cyc; i++) begin
      if (int'(limit_o) != elo || peak_o) check(1'b0, "R5 hold code", int'(limit_o), elo);
      step();
    end
    check(int'(limit_o) == elo && !peak_o, "R5/R8 hold code", int'(limit_o), elo);
    drive_i = 1'b0;
    step();
    check(limit_o == '0 && !peak_o, "R6 idle after drop", int'(limit_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int hv[7] = '{0, 1, 950, 1899, 1900, 1901, 2047};
    int lv[6] = '{0, 949, 950, 951, 1023, 2047};
    int pv[7] = '{0, 1, 2, 3, 7, 64, 255};
    int pv3[3] = '{0, 1, 5};
    repeat (3) @(negedge clk);
    check(limit_o == '0 && !peak_o, "R1 reset idle", int'(limit_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(limit_o == '0 && !peak_o, "R1 idle after reset", int'(limit_o), 0);

    // R3 sweep of peak lengths, tick every clock
    div = 1;
    foreach (pv[i]) pulse(pv[i], 1200, 600, 3);
    // R3 with sparse ticks
    div = 3; phase = 0;
    foreach (pv3[i]) pulse(pv3[i], 800, 400, 5);
    div = 1; phase = 0;

    // R7 R8 clamp grid
    foreach (hv[i]) foreach (lv[j]) pulse(1, hv[i], lv[j], 2);

    // R9 restart after a pulse cut during peak
    hi_code_i = 11'd1000; lo_code_i = 11'd500; peak_i = 8'd4;
    drive_i = 1'b1;
    for (int i = 0; i < 100; i++) step();
    check(peak_o == 1'b1, "R9 still in peak before cut", int'(peak_o), 1);
    drive_i = 1'b0;
    step();
    check(limit_o == '0 && !peak_o, "R9/R6 cut to idle", int'(limit_o), 0);
    pulse(4, 1000, 500, 2);

    // R11 peak time change mid-pulse ignored
    hi_code_i = 11'd300; lo_code_i = 11'd200; peak_i = 8'd2;
    drive_i = 1'b1;
    step();
    seen = 0;
    for (int i = 0; i < 10; i++) step();
    peak_i = 8'd200;
    for (int i = 0; i < 20000 && peak_o; i++) step();
    check(seen == 128, "R11 captured peak length", seen, 128);
    check(int'(limit_o) == 200, "R11 hold after short peak", int'(limit_o), 200);
    drive_i = 1'b0;
    step();
    check(limit_o == '0, "R6 final idle", int'(limit_o), 0);
    finish_run();
  end
endmodule